// File: doc/BRIEF.md
# Round-Robin DMA Channel Arbiter

This block picks which of four DMA channels may run a transfer next. Each channel raises a request line. The arbiter keeps a circular ranking of the channels and gives a one-hot grant to the requesting channel that currently ranks highest. The grant stays on that channel for the whole transfer and is never taken away by a later request. When the transfer-done pulse arrives, the finished channel drops to the bottom of the ring and the channel after it moves to the top. Any requests still waiting then compete again under the new ranking.

The ranking is stored as a small pointer to the top channel. The full order is exported as a status vector for debug, one channel index per slot. A transfer-busy input stops new grants while the shared transfer path is occupied. Address generation, data movement and bus signalling belong to other blocks.

Top module: `rr_arbiter`

## Requirements
- R1: After reset, `grantOut` is zero and `orderOut` reads 8'hE4. Slot k is held in bits [2k+1:2k], and slot 0 is the highest rank, so this value is the order 0>1>2>3.
- R2: `grantOut` is registered and never has more than one bit set. While no grant is held and `xferBusy` is low, a nonzero `reqIn` sampled at a clock edge produces a grant after that same edge.
- R3: When several channels request together, the grant goes to the requesting channel that ranks highest in `orderOut`.
- R4: A held grant does not change while `xferDone` is low. New requests from other channels do not displace it, and neither does `xferBusy`.
- R5: An `xferDone` sampled while channel c holds the grant clears `grantOut` after that edge. The top slot becomes (c+1) mod 4, so c ends up lowest. For example, 0>1>2>3 becomes 1>2>3>0 (8'h39) when channel 0 finishes.
- R6: Requests still pending are arbitrated against the rotated order at the next edge after the release.
- R7: An `xferDone` pulse while no grant is held has no effect: the order does not change and no grant appears.
- R8: With no requests, `grantOut` stays zero and `orderOut` does not change.
- R9: While no grant is held and `xferBusy` is high, no grant is issued, whatever the requests are.
- R10: A request that is withdrawn before it is granted produces no grant and leaves the order unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 4 | Per-channel transfer requests |
| xferBusy | input | 1 | Shared transfer path occupied; blocks new grants |
| xferDone | input | 1 | One-cycle pulse that ends the granted transfer |
| grantOut | output | 4 | One-hot grant, registered |
| orderOut | output | 8 | Current ranking: slot k in bits [2k+1:2k], slot 0 highest |

## Verification
The hardest situation to reach from the ports is a request that stays pending across one or more rotations. It has to arrive during another channel's transfer, lose once to a channel that ranks higher under the new order, and only then win. The directed stimulus replays exactly this chain. Channels 0 and 3 request together, channel 1 joins while channel 0 runs, and three done pulses walk the order through 1>2>3>0, 2>3>0>1 and back to 0>1>2>3. After that, a long random phase with `xferBusy` held high at times and done pulses landing both with and without a grant is compared against a behavioural model on every cycle.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic takeGrant;  // latch the winner of this cycle's arbitration
    logic dropGrant;  // release the grant and rotate the ring
  } arbStrobe_t;
endpackage

// File: rtl/rr_arb_ctrl.sv
module rr_arb_ctrl
  import rr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       xferBusy,
  input  logic       xferDone,
  output arbStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_HOLD} state_t;
  state_t stateQ, stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (anyReq && !xferBusy) begin
        strobe.takeGrant = 1'b1;
        stateD = ST_HOLD;
      end
      ST_HOLD: if (xferDone) begin
        strobe.dropGrant = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/rr_arb_datapath.sv
module rr_arb_datapath
  import rr_arb_pkg::*;
#(
  parameter  int NUM_CH = 4,          // must be a power of two
  localparam int PTR_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       reqIn,
  input  arbStrobe_t              strobe,
  output logic                    anyReq,
  output logic [NUM_CH-1:0]       grantOut,
  output logic [NUM_CH*PTR_W-1:0] orderOut
);
  logic [PTR_W-1:0]  headQ;      // channel in the top slot
  logic [PTR_W-1:0]  grantIdxQ;  // index of the held grant
  logic [NUM_CH-1:0] grantQ;
  logic [PTR_W-1:0]  pickIdx;
  logic              pickFound;

  assign anyReq = |reqIn;

  // Walk the ring from the top slot; the first requester wins
  always_comb begin
    pickIdx   = headQ;
    pickFound = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      logic [PTR_W-1:0] cand;
      cand = headQ + PTR_W'(k);
      if (!pickFound && reqIn[cand]) begin
        pickIdx   = cand;
        pickFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ     <= '0;
      grantIdxQ <= '0;
      grantQ    <= '0;
    end else if (strobe.takeGrant) begin
      grantQ    <= NUM_CH'(1) << pickIdx;
      grantIdxQ <= pickIdx;
    end else if (strobe.dropGrant) begin
      grantQ    <= '0;
      headQ     <= grantIdxQ + 1'b1;
    end
  end

  assign grantOut = grantQ;

  for (genvar slot = 0; slot < NUM_CH; slot++) begin : g_order
    assign orderOut[slot*PTR_W +: PTR_W] = headQ + PTR_W'(slot);
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter
  import rr_arb_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int PTR_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       reqIn,
  input  logic                    xferBusy,
  input  logic                    xferDone,
  output logic [NUM_CH-1:0]       grantOut,
  output logic [NUM_CH*PTR_W-1:0] orderOut
);
  arbStrobe_t strobe;
  logic       anyReq;

  rr_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .xferBusy (xferBusy),
    .xferDone (xferDone),
    .strobe   (strobe)
  );

  rr_arb_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .strobe   (strobe),
    .anyReq   (anyReq),
    .grantOut (grantOut),
    .orderOut (orderOut)
  );
endmodule

// File: rtl/rr_arbiter_chk.sv
module rr_arbiter_chk #(
  parameter  int NUM_CH = 4,
  localparam int PTR_W  = $clog2(NUM_CH)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_CH-1:0]       reqIn,
  input logic                    xferBusy,
  input logic                    xferDone,
  input logic [NUM_CH-1:0]       grantOut,
  input logic [NUM_CH*PTR_W-1:0] orderOut
);
  logic [PTR_W-1:0]  headNow;
  logic [PTR_W-1:0]  predIdx;
  logic [NUM_CH-1:0] predOneHot;
  logic              held;

  assign headNow    = orderOut[PTR_W-1:0];
  assign predIdx    = headNow - 1'b1;
  assign predOneHot = NUM_CH'(1) << predIdx;
  assign held       = |grantOut;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  p_grant_from_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!held && (|reqIn) && !xferBusy) |=> (held && ((grantOut & $past(reqIn)) == grantOut)));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (held && !xferDone) |=> $stable(grantOut));

  p_release_rotate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (held && xferDone) |=> (!held && ($past(grantOut) == predOneHot)));

  p_order_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(held && xferDone) |=> $stable(orderOut));

  p_no_req_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!held && (reqIn == '0)) |=> !held);

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!held && xferBusy) |=> !held);
endmodule

bind rr_arbiter rr_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqIn    (reqIn),
  .xferBusy (xferBusy),
  .xferDone (xferDone),
  .grantOut (grantOut),
  .orderOut (orderOut)
);

// File: tb/sim_rr_arbiter.sv
module sim_rr_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqIn = '0;
  logic       xferBusy = 1'b0;
  logic       xferDone = 1'b0;
  logic [3:0] grantOut;
  logic [7:0] orderOut;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;
  bit  modelOn   = 1'b0;

  // behavioural reference
  int mHead  = 0;
  int mGrant = -1;

  rr_arbiter u0 (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .xferBusy (xferBusy),
    .xferDone (xferDone),
    .grantOut (grantOut),
    .orderOut (orderOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] orderOf(int head);
    logic [7:0] v;
    for (int s = 0; s < 4; s++) v[s*2 +: 2] = 2'((head + s) % 4);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at every edge, compare after the registers settle
  always @(posedge clk) begin
    if (!rstN) begin
      mHead = 0; mGrant = -1;
    end else if (mGrant >= 0) begin
      if (xferDone) begin
        mHead  = (mGrant + 1) % 4;
        mGrant = -1;
      end
    end else if (!xferBusy) begin
      for (int k = 0; k < 4; k++)
        if (mGrant < 0 && reqIn[(mHead + k) % 4]) mGrant = (mHead + k) % 4;
    end
    #2;
    if (modelOn) begin
      check("R2 model grant", 32'(grantOut), (mGrant < 0) ? 32'd0 : 32'(4'b1 << mGrant));
      check("R5 model order", 32'(orderOut), 32'(orderOf(mHead)));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    modelOn = 1'b1;
    // R1 reset state
    check("R1 grant", 32'(grantOut), 32'd0);
    check("R1 order", 32'(orderOut), 32'hE4);

    // channels 0 and 3 together: 0 wins (R3)
    reqIn = 4'b1001; tick();
    check("R3 grant ch0", 32'(grantOut), 32'b0001);
    reqIn = 4'b1000; xferBusy = 1'b1; tick();
    // channel 1 arrives mid-transfer (R4)
    reqIn = 4'b1010; tick(3);
    check("R4 hold ch0", 32'(grantOut), 32'b0001);
    xferDone = 1'b1; xferBusy = 1'b0; tick(); xferDone = 1'b0;
    check("R5 release ch0", 32'(grantOut), 32'd0);
    check("R5 order 1>2>3>0", 32'(orderOut), 32'h39);
    tick();
    check("R6 regrant ch1", 32'(grantOut), 32'b0010);
    reqIn = 4'b1000; tick(2);
    xferDone = 1'b1; tick(); xferDone = 1'b0;
    check("R5 order 2>3>0>1", 32'(orderOut), 32'h4E);
    tick();
    check("R6 regrant ch3", 32'(grantOut), 32'b1000);
    reqIn = 4'b0000; tick();
    xferDone = 1'b1; tick(); xferDone = 1'b0;
    check("R5 order back 0>1>2>3", 32'(orderOut), 32'hE4);

    // stray done (R7), idle (R8)
    xferDone = 1'b1; tick(); xferDone = 1'b0;
    check("R7 order", 32'(orderOut), 32'hE4);
    check("R7 grant", 32'(grantOut), 32'd0);
    tick(4);
    check("R8 idle grant", 32'(grantOut), 32'd0);
    check("R8 idle order", 32'(orderOut), 32'hE4);

    // busy blocks (R9)
    xferBusy = 1'b1; reqIn = 4'b0100; tick(3);
    check("R9 blocked", 32'(grantOut), 32'd0);
    xferBusy = 1'b0; tick();
    check("R9 released ch2", 32'(grantOut), 32'b0100);
    reqIn = 4'b0000; xferDone = 1'b1; tick(); xferDone = 1'b0;
    check("R5 order 3>0>1>2", 32'(orderOut), 32'h93);

    // withdrawn request (R10)
    xferBusy = 1'b1; reqIn = 4'b0010; tick(2);
    reqIn = 4'b0000; xferBusy = 1'b0; tick(3);
    check("R10 no grant", 32'(grantOut), 32'd0);
    check("R10 order", 32'(orderOut), 32'h93);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      reqIn    = 4'($urandom_range(0, 15));
      xferBusy = ($urandom_range(0, 3) == 0);
      xferDone = ($urandom_range(0, 9) < 3);
      tick();
    end
    reqIn = '0; xferBusy = 1'b0; xferDone = 1'b0;
    tick(2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule